// File: doc/BRIEF.md
# Bus Transaction Timeout Monitor

This block sits passively on a synchronous bus and watches every transaction on it, whichever agents take part. A transaction opens with a start cycle, in which the start strobe is low while the acknowledge strobe is high. From that cycle on, the monitor counts bus clocks. If the transaction has not reached its closing acknowledge within a fixed window, the monitor declares a timeout. The window defaults to 256 cycles, which is 25.6 microseconds at a 10 MHz bus clock.

A block transfer is timed as one unit. Its intermediate beat acknowledges do not restart the count, and only the acknowledge that carries the last-beat flag ends the transaction. The block has no input that tells it which agent started a transaction, so it treats transfers between two other cards exactly like its own.

On a timeout the monitor does three things. It raises a one-cycle pulse, it sets a sticky flag that stays up until software clears it, and it drives an error-response enable for a configurable number of cycles. It then goes back to idle and waits for the next start cycle.

Top module: `bus_txn_watchdog`

## Requirements
- R1: A start cycle is a cycle with `start_n` = 0 and `ack_n` = 1 while the monitor is idle. That cycle is cycle 0, and the cycles after it are numbered 1, 2, and so on.
- R2: A closing acknowledge in any cycle from 1 to LIMIT (default 256), inclusive, ends the transaction with no timeout. A closing acknowledge is `ack_n` = 0 with `start_n` = 1.
- R3: If no closing acknowledge has arrived by cycle LIMIT, `timeout_pulse` is high in the cycle that follows cycle LIMIT. An acknowledge that arrives after that is ignored.
- R4: In a transaction whose start cycle has `blk_xfer` = 1, acknowledges with `last_beat` = 0 do not end it and do not restart the count. Only an acknowledge with `last_beat` = 1 ends it.
- R5: An attention cycle (`start_n` = 0 and `ack_n` = 0) does not start a transaction.
- R6: A start cycle that arrives while a transaction is already being timed is ignored. The count runs on from the original start.
- R7: `timeout_pulse` is high for exactly one cycle per timeout. After it, the monitor is idle and the next start cycle arms it.
- R8: `timeout_sticky` is set by a timeout and stays set until `clr_sticky` is sampled high. When a timeout and a clear occur in the same cycle, the flag ends up set.
- R9: `err_drive` is high for exactly ERR_HOLD cycles (default 2), starting in the same cycle as `timeout_pulse`.
- R10: After reset, `timeout_pulse`, `timeout_sticky` and `err_drive` are all low.
- R11: `blk_xfer` is sampled only in the start cycle. Changes to it during a transaction have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_n | input | 1 | Bus start strobe, active low |
| ack_n | input | 1 | Bus acknowledge strobe, active low |
| blk_xfer | input | 1 | Transfer-mode line, high for a block transfer (sampled at start) |
| last_beat | input | 1 | Status line marking the final beat of a block transfer |
| clr_sticky | input | 1 | Clears the sticky timeout flag |
| timeout_pulse | output | 1 | One-cycle timeout indication |
| timeout_sticky | output | 1 | Sticky timeout flag |
| err_drive | output | 1 | Enable for the bus error response |

## Verification
The bench sweeps the closing acknowledge across every cycle from 1 to 260. This catches an off-by-one at either end of the window: a design that counted from the cycle after start would let cycle 257 pass, and one that used a strict compare would fire on a transaction that completes at 256.

Block transfers are run with ack trains that stop short of the window edge, end exactly on it, and overrun it. A design that stopped or restarted on intermediate beats would miss the overrunning cases.

Further cases cover attention cycles, a second start in the middle of a transaction, and `blk_xfer` flipping after the start cycle. A design that armed on attention cycles, reloaded its count on a second start, or tracked the live mode line would show a spurious or shifted pulse in these cases. A clear that lands on the same edge as a timeout checks that the set takes priority.

// File: rtl/bus_wd_pkg.sv
package bus_wd_pkg;

   // Classification of one bus cycle from the two strobes
   typedef enum logic [1:0] {
      CYC_IDLE  = 2'd0,
      CYC_START = 2'd1,
      CYC_ATTN  = 2'd2,
      CYC_ACK   = 2'd3
   } cyc_kind_e;

   function automatic cyc_kind_e classify(input logic start_n, input logic ack_n);
      case ({start_n, ack_n})
         2'b01:   return CYC_START;
         2'b00:   return CYC_ATTN;
         2'b10:   return CYC_ACK;
         default: return CYC_IDLE;
      endcase
   endfunction

endpackage

// File: rtl/txn_cycle_decode.sv
module txn_cycle_decode
   import bus_wd_pkg::*;
(
   input  logic      start_n,
   input  logic      ack_n,
   input  logic      last_beat,
   output cyc_kind_e kind_o,
   output logic      is_start_o,
   output logic      is_ack_o,
   output logic      ack_last_o
);

   always_comb begin
      kind_o     = classify(start_n, ack_n);
      is_start_o = (kind_o == CYC_START);
      is_ack_o   = (kind_o == CYC_ACK);
      ack_last_o = is_ack_o && last_beat;
   end

endmodule

// File: rtl/txn_window_timer.sv
module txn_window_timer #(
   parameter int LIMIT = 256
) (
   input  logic clk,
   input  logic rst_n,
   input  logic is_start_i,
   input  logic is_attn_i,
   input  logic is_ack_i,
   input  logic ack_last_i,
   input  logic blk_mode_i,
   output logic busy_o,
   output logic expire_o
);

   localparam int CNT_W = $clog2(LIMIT + 1);
   localparam logic [CNT_W-1:0] LIM_V = CNT_W'(LIMIT);

   generate
      if (LIMIT < 2) begin : g_bad_limit
         $error("txn_window_timer: LIMIT must be at least 2");
      end
   endgenerate

   logic             busy_q;
   logic             blk_q;
   logic [CNT_W-1:0] cnt_q;
   logic             closing;

   // A plain transaction closes on any ack; a block closes only on the last beat
   assign closing  = busy_q && (blk_q ? ack_last_i : is_ack_i);
   assign expire_o = busy_q && (cnt_q == LIM_V) && !closing;
   assign busy_o   = busy_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         blk_q  <= 1'b0;
         cnt_q  <= '0;
      end else if (!busy_q) begin
         if (is_start_i) begin
            busy_q <= 1'b1;
            blk_q  <= blk_mode_i;
            cnt_q  <= CNT_W'(1);
         end
      end else if (closing || expire_o) begin
         busy_q <= 1'b0;
         cnt_q  <= '0;
      end else begin
         cnt_q  <= cnt_q + 1'b1;
      end
   end

   // R3
   no_overrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy_q |-> (cnt_q <= LIM_V && cnt_q != '0));

   // R5
   attn_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_q && is_attn_i) |=> !busy_q);

   // R6
   restart_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && is_start_i && cnt_q != LIM_V) |=> (busy_q && cnt_q == $past(cnt_q) + 1'b1));

   // R11
   mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && $past(busy_q)) |-> $stable(blk_q));

endmodule

// File: rtl/timeout_report.sv
module timeout_report #(
   parameter int ERR_HOLD = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic expire_i,
   input  logic clr_i,
   output logic pulse_o,
   output logic sticky_o,
   output logic err_o
);

   generate
      if (ERR_HOLD < 1) begin : g_bad_hold
         $error("timeout_report: ERR_HOLD must be at least 1");
      end
   endgenerate

   logic pulse_q;
   logic sticky_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pulse_q  <= 1'b0;
         sticky_q <= 1'b0;
      end else begin
         pulse_q <= expire_i;
         if (expire_i)   sticky_q <= 1'b1;
         else if (clr_i) sticky_q <= 1'b0;
      end
   end

   assign pulse_o  = pulse_q;
   assign sticky_o = sticky_q;

   generate
      if (ERR_HOLD == 1) begin : g_err_single
         assign err_o = pulse_q;
      end else begin : g_err_stretch
         localparam int HW = $clog2(ERR_HOLD + 1);
         logic [HW-1:0] hold_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)              hold_q <= '0;
            else if (expire_i)       hold_q <= HW'(ERR_HOLD);
            else if (hold_q != '0)   hold_q <= hold_q - 1'b1;
         end
         assign err_o = (hold_q != '0);
      end
   endgenerate

   // R7
   pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pulse_q |=> !pulse_q);

   // R8
   sticky_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pulse_q |-> sticky_q);

   // R8
   sticky_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i && !expire_i) |=> !sticky_q);

   // R9
   err_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(err_o) |-> pulse_q);

endmodule

// File: rtl/bus_txn_watchdog.sv
module bus_txn_watchdog #(
   parameter int LIMIT    = 256,
   parameter int ERR_HOLD = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start_n,
   input  logic ack_n,
   input  logic blk_xfer,
   input  logic last_beat,
   input  logic clr_sticky,
   output logic timeout_pulse,
   output logic timeout_sticky,
   output logic err_drive
);
   import bus_wd_pkg::*;

   cyc_kind_e kind;
   logic      is_start;
   logic      is_ack;
   logic      ack_last;
   logic      busy;
   logic      expire;

   txn_cycle_decode u_decode (
      .start_n    (start_n),
      .ack_n      (ack_n),
      .last_beat  (last_beat),
      .kind_o     (kind),
      .is_start_o (is_start),
      .is_ack_o   (is_ack),
      .ack_last_o (ack_last)
   );

   txn_window_timer #(.LIMIT(LIMIT)) u_timer (
      .clk        (clk),
      .rst_n      (rst_n),
      .is_start_i (is_start),
      .is_attn_i  (kind == CYC_ATTN),
      .is_ack_i   (is_ack),
      .ack_last_i (ack_last),
      .blk_mode_i (blk_xfer),
      .busy_o     (busy),
      .expire_o   (expire)
   );

   timeout_report #(.ERR_HOLD(ERR_HOLD)) u_report (
      .clk      (clk),
      .rst_n    (rst_n),
      .expire_i (expire),
      .clr_i    (clr_sticky),
      .pulse_o  (timeout_pulse),
      .sticky_o (timeout_sticky),
      .err_o    (err_drive)
   );

   // R7
   idle_after_timeout_chk: assert property (@(posedge clk) disable iff (!rst_n)
      expire |=> !busy);

endmodule

// File: tb/bus_txn_watchdog_tb.sv
module bus_txn_watchdog_tb;

   localparam int LIM  = 256;
   localparam int HOLD = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start_n = 1'b1, ack_n = 1'b1, blk_xfer = 1'b0, last_beat = 1'b0, clr_sticky = 1'b0;
   logic timeout_pulse, timeout_sticky, err_drive;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   bus_txn_watchdog #(.LIMIT(LIM), .ERR_HOLD(HOLD)) u_dut (
      .clk(clk), .rst_n(rst_n), .start_n(start_n), .ack_n(ack_n),
      .blk_xfer(blk_xfer), .last_beat(last_beat), .clr_sticky(clr_sticky),
      .timeout_pulse(timeout_pulse), .timeout_sticky(timeout_sticky), .err_drive(err_drive)
   );

   task automatic chk(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   // last_at: cycle of the closing ack (0 = never); step: beat spacing for block acks
   task automatic run_trial(input string tag, input bit blk, input int last_at, input int step,
                            input bit attn, input int restart_at, input int clr_at);
      int  npulse = 0;
      int  pidx   = -1;
      int  nerr   = 0;
      bit  exp_to = !attn && (last_at == 0 || last_at > LIM);
      int  win    = ((last_at > LIM + 1) ? last_at : LIM + 1) + HOLD + 3;
      @(negedge clk);
      start_n = 1'b0; ack_n = attn ? 1'b0 : 1'b1; blk_xfer = blk; last_beat = 1'b0;
      for (int j = 1; j <= win; j++) begin
         @(negedge clk);
         if (timeout_pulse) begin npulse++; if (pidx < 0) pidx = j; end
         if (err_drive) nerr++;
         start_n = 1'b1; ack_n = 1'b1; last_beat = 1'b0; clr_sticky = 1'b0;
         blk_xfer = !blk;                      // R11: mode line flips after start
         if (j == restart_at) start_n = 1'b0;
         if (!blk && j == last_at) ack_n = 1'b0;
         if (blk) begin
            if (j == last_at) begin ack_n = 1'b0; last_beat = 1'b1; end
            else if (step > 0 && j % step == 0 && (last_at == 0 || j < last_at)) ack_n = 1'b0;
         end
         if (j == clr_at) clr_sticky = 1'b1;
      end
      @(negedge clk);
      start_n = 1'b1; ack_n = 1'b1; last_beat = 1'b0; clr_sticky = 1'b0; blk_xfer = 1'b0;
      chk(tag, "timeout count", npulse, exp_to ? 1 : 0);
      if (exp_to) begin
         chk("R1", "timeout cycle index", pidx, LIM + 1);
         chk("R7", "pulse width", npulse, 1);
      end
      chk("R9", "err_drive cycles", nerr, exp_to ? HOLD : 0);
      chk("R8", "sticky after trial", int'(timeout_sticky), exp_to ? 1 : 0);
      clr_sticky = 1'b1;
      @(negedge clk);
      clr_sticky = 1'b0;
      @(negedge clk);
      chk("R8", "sticky after clear", int'(timeout_sticky), 0);
   endtask

   initial begin : watchdog
      for (int c = 0; c < 190000; c++) begin
         @(posedge clk);
         if (done) disable watchdog;
      end
      errors++;
      checks++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R10: outputs during and after reset
      chk("R10", "pulse in reset", int'(timeout_pulse), 0);
      chk("R10", "sticky in reset", int'(timeout_sticky), 0);
      chk("R10", "err in reset", int'(err_drive), 0);
      rst_n = 1'b1;
      @(negedge clk);
      // R2/R3: sweep closing ack over every cycle 1..260
      for (int k = 1; k <= LIM + 4; k++)
         run_trial((k <= LIM) ? "R2" : "R3", 1'b0, k, 0, 1'b0, 0, 0);
      // R3: no ack at all
      run_trial("R3", 1'b0, 0, 0, 1'b0, 0, 0);
      // R11: single transfer closes while mode line is high
      run_trial("R11", 1'b0, 10, 0, 1'b0, 0, 0);
      // R4: block transfers
      run_trial("R4", 1'b1, LIM, 2, 1'b0, 0, 0);
      run_trial("R4", 1'b1, 200, 4, 1'b0, 0, 0);
      run_trial("R4", 1'b1, LIM + 2, 2, 1'b0, 0, 0);
      run_trial("R4", 1'b1, 0, 3, 1'b0, 0, 0);
      run_trial("R4", 1'b1, 1, 0, 1'b0, 0, 0);
      // R5: attention cycle does not arm
      run_trial("R5", 1'b0, 0, 0, 1'b1, 0, 0);
      // R6: second start mid-transaction is ignored
      run_trial("R6", 1'b0, 0, 0, 1'b0, 100, 0);
      // R8: clear on the same edge as the timeout, set wins
      run_trial("R8", 1'b0, 0, 0, 1'b0, 0, LIM);
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule